// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small processor core and decides which interrupt the core should service next. It gathers request flags from up to 32 priority slots. Each slot may be fed by several member flags, and each member flag has its own enable bit. The slot is grouped into one of four classes. The highest reset-class slot and a (non)maskable slot directly below it ignore the global interrupt enable. The ordinary maskable slots need it. A band of low slots is permanently unused.

Each cycle the controller picks the highest-numbered pending slot. On the next clock edge it registers an interrupt request, the slot number and the word address of that slot's vector. Vectors sit in the top 64 bytes of the 16-bit address space, two bytes apart. The core acknowledges a request, which clears the controller's global enable. The controller also watches instruction fetch addresses. A fetch from the low peripheral register window is treated like any other reset cause.

Top module: `irq_vector_ctl`

## Requirements
- R1: A synchronous active-high reset leaves, at the edge where it is sampled, `irq_o`=0, `rst_req_o`=1, `slot_o`=31 and `vec_addr_o`=0xFFFE, with the global enable cleared. One edge after reset is released, `irq_o`=1 with slot 31.
- R2: Whenever `irq_o` is 1, `vec_addr_o` equals 0xFFC0 + 2 × `slot_o`, so slot 31 gives 0xFFFE and slot 14 gives 0xFFDC.
- R3: Any bit of `rst_src` set before an edge makes `rst_req_o`=1, `irq_o`=1 and `slot_o`=31 after that edge, whatever the enables or other pending slots. The reset request stays latched after the cause goes away.
- R4: A fetch with `fetch_valid`=1 and `fetch_addr` from 0x0000 to 0x01FF acts as a reset cause as in R3. Address 0x0200 and above does not, and neither does any address while `fetch_valid`=0.
- R5: Slot 30 is pending when any of its member flags is set together with that member's enable, regardless of the global enable. With the member's enable clear, that member flag has no effect.
- R6: A slot from 14 to 29 is pending only when some member flag and its enable are both set and the global enable is 1.
- R7: Member m of slot s uses bit s×8+m of `src_flag` and `src_en`. One enabled, set member is enough to make its slot pending. Set flags whose enables are clear are ignored.
- R8: Slots 0 to 13 never raise a request, whatever their flags and enables.
- R9: When several slots are pending, the one with the largest number is reported.
- R10: An acknowledge clears the global enable. A maskable request disappears two edges after the acknowledge edge, and one edge after it the old choice is still shown. The acknowledge does not clear flags, so an enabled slot-30 flag keeps requesting. An acknowledge while `slot_o`=31 clears the latched reset request, and `rst_req_o` drops two edges later.
- R11: `gie_wr` loads `gie_wr_val` into the global enable, with its effect on `irq_o` seen two edges later. An acknowledge at the same edge takes precedence and leaves it cleared.
- R12: Member flags and enables of slot 31 are ignored. Only reset causes select slot 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 256 | Member flags, bit s×8+m is member m of slot s |
| src_en | input | 256 | Per-member enables, same layout |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wr_val | input | 1 | Value written to the global enable |
| rst_src | input | 4 | Reset causes (power-up, pin, watchdog, key violation) |
| fetch_valid | input | 1 | An instruction fetch is happening |
| fetch_addr | input | 16 | Address of that fetch |
| ack | input | 1 | Core accepts the request shown on `slot_o` |
| irq_o | output | 1 | Registered interrupt request |
| vec_addr_o | output | 16 | Registered vector word address |
| slot_o | output | 5 | Registered winning slot number |
| rst_req_o | output | 1 | Registered reset request |

## Verification
Flag, enable, fetch and reset-cause changes must appear on the registered outputs one edge after they are applied. The bench therefore drives at a falling edge and samples at the next falling edge. Writes to the global enable, and acknowledges, pass through one state register before selection, so their results are sampled two falling edges later. The acknowledge test also samples the intermediate edge, where the old choice must still be visible. The table walk writes the enable first and the flags one edge later, so each row is judged on exactly the two edges it needs.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int unsigned ADDR_W = 16;

  typedef enum logic [1:0] {
    CL_UNUSED = 2'd0,
    CL_RESET  = 2'd1,
    CL_NMI    = 2'd2,
    CL_MASK   = 2'd3
  } slot_class_e;

  // Class of a slot given the slot count and the first used slot.
  function automatic slot_class_e slot_class(int unsigned slot,
                                             int unsigned slots,
                                             int unsigned first_used);
    if (slot < first_used)       return CL_UNUSED;
    else if (slot == slots - 1)  return CL_RESET;
    else if (slot == slots - 2)  return CL_NMI;
    else                         return CL_MASK;
  endfunction

  // Word address of a slot's vector: base plus two bytes per slot.
  function automatic logic [ADDR_W-1:0] vec_of(logic [ADDR_W-1:0] base,
                                               int unsigned slot);
    return base + ADDR_W'(slot * 2);
  endfunction

  // True for fetches below the peripheral register limit.
  function automatic logic in_low_window(logic [ADDR_W-1:0] addr,
                                         logic [ADDR_W-1:0] limit);
    return addr < limit;
  endfunction

endpackage

// File: rtl/irq_slot_gate.sv
module irq_slot_gate
  import irq_vec_pkg::*;
#(
  parameter int unsigned SLOTS      = 32,
  parameter int unsigned GRP        = 8,
  parameter int unsigned FIRST_USED = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOTS*GRP-1:0]  flags,
  input  logic [SLOTS*GRP-1:0]  enables,
  input  logic                  gie,
  input  logic                  rst_pend,
  output logic [SLOTS-1:0]      pend
);

  logic [SLOTS-1:0] member_hit;   // any enabled member flag, before class gating

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam slot_class_e CLS = slot_class(s, SLOTS, FIRST_USED);
    assign member_hit[s] = |(flags[s*GRP +: GRP] & enables[s*GRP +: GRP]);

    if (CLS == CL_UNUSED) begin : g_unused
      assign pend[s] = 1'b0;
    end else if (CLS == CL_RESET) begin : g_reset
      assign pend[s] = rst_pend;
    end else if (CLS == CL_NMI) begin : g_nmi
      assign pend[s] = member_hit[s];
    end else begin : g_mask
      assign pend[s] = member_hit[s] & gie;
      assert_mask_needs_gie_R6: assert property (@(posedge clk) disable iff (rst)
        pend[s] |-> (gie && member_hit[s]));
    end
  end

  // R5: the (non)maskable slot follows its members even with the global enable clear.
  assert_nmi_ignores_gie_R5: assert property (@(posedge clk) disable iff (rst)
    (member_hit[SLOTS-2] && !gie) |-> pend[SLOTS-2]);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              rst,
  input  logic [SLOTS-1:0]  pend,
  output logic              valid,
  output logic [SLOT_W-1:0] idx
);

  // Ascending scan: the last pending slot seen, the highest number, wins.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (pend[i]) begin
        valid = 1'b1;
        idx   = i[SLOT_W-1:0];
      end
    end
  end

  always_comb begin
    if (!rst) begin
      assert_pick_is_pending_R9: assert (!valid || pend[idx]);
      assert_pick_is_highest_R9: assert (!valid || ((pend >> idx) == SLOTS'(1)));
      assert_pick_valid_R9:      assert (valid == (pend != '0));
    end
  end

endmodule

// File: rtl/irq_state_ctl.sv
module irq_state_ctl #(
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic [SLOT_W-1:0] ack_slot,
  input  logic              gie_wr,
  input  logic              gie_wr_val,
  input  logic              rst_now,
  output logic              gie_q,
  output logic              rst_latch_q
);

  logic ack_reset;   // acknowledge of the reset slot
  assign ack_reset = ack && (ack_slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q       <= 1'b0;
      rst_latch_q <= 1'b1;
    end else begin
      if (ack)         gie_q <= 1'b0;
      else if (gie_wr) gie_q <= gie_wr_val;
      rst_latch_q <= rst_now | (rst_latch_q & ~ack_reset);
    end
  end

  assert_ack_clears_gie_R10_R11: assert property (@(posedge clk) disable iff (rst)
    ack |=> !gie_q);
  assert_cause_latched_R3: assert property (@(posedge clk) disable iff (rst)
    rst_now |=> rst_latch_q);
  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (rst_latch_q && !ack) |=> rst_latch_q);

endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vec_pkg::*;
#(
  parameter int unsigned SLOTS      = 32,
  parameter int unsigned GRP        = 8,
  parameter int unsigned FIRST_USED = 14,
  parameter int unsigned NRST       = 4,
  parameter logic [15:0] VEC_BASE   = 16'hFFC0,
  parameter logic [15:0] LOW_LIMIT  = 16'h0200,
  localparam int unsigned SLOT_W    = $clog2(SLOTS),
  localparam int unsigned FLAG_W    = SLOTS * GRP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] src_flag,
  input  logic [FLAG_W-1:0] src_en,
  input  logic              gie_wr,
  input  logic              gie_wr_val,
  input  logic [NRST-1:0]   rst_src,
  input  logic              fetch_valid,
  input  logic [15:0]       fetch_addr,
  input  logic              ack,
  output logic              irq_o,
  output logic [15:0]       vec_addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              rst_req_o
);

  logic              low_fetch;     // fetch into the peripheral register window
  logic              rst_now;       // any reset cause this cycle
  logic              gie_q;
  logic              rst_latch_q;
  logic              rst_pend;      // reset slot pending
  logic [SLOTS-1:0]  pend;
  logic              pick_valid;
  logic [SLOT_W-1:0] pick_idx;

  assign low_fetch = fetch_valid && in_low_window(fetch_addr, LOW_LIMIT);
  assign rst_now   = (|rst_src) | low_fetch;
  assign rst_pend  = rst_now | rst_latch_q;

  irq_state_ctl #(.SLOTS(SLOTS)) u_state (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .ack_slot    (slot_o),
    .gie_wr      (gie_wr),
    .gie_wr_val  (gie_wr_val),
    .rst_now     (rst_now),
    .gie_q       (gie_q),
    .rst_latch_q (rst_latch_q)
  );

  irq_slot_gate #(.SLOTS(SLOTS), .GRP(GRP), .FIRST_USED(FIRST_USED)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .flags    (src_flag),
    .enables  (src_en),
    .gie      (gie_q),
    .rst_pend (rst_pend),
    .pend     (pend)
  );

  irq_prio_pick #(.SLOTS(SLOTS)) u_pick (
    .rst   (rst),
    .pend  (pend),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      slot_o     <= SLOT_W'(SLOTS - 1);
      vec_addr_o <= vec_of(VEC_BASE, SLOTS - 1);
      rst_req_o  <= 1'b1;
    end else begin
      irq_o      <= pick_valid;
      slot_o     <= pick_idx;
      vec_addr_o <= vec_of(VEC_BASE, int'(pick_idx));
      rst_req_o  <= rst_pend;
    end
  end

  assert_vec_matches_slot_R2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_addr_o == VEC_BASE + {slot_o, 1'b0}));
  assert_no_unused_slot_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (slot_o >= SLOT_W'(FIRST_USED)));
  assert_cause_wins_R3_R4: assert property (@(posedge clk) disable iff (rst)
    rst_now |=> (rst_req_o && irq_o && slot_o == SLOT_W'(SLOTS - 1)));
  assert_mask_had_gie_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && slot_o < SLOT_W'(SLOTS - 2)) |-> $past(gie_q));
  assert_reset_req_means_irq_R1: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && !$past(rst)) |-> (irq_o && slot_o == SLOT_W'(SLOTS - 1)));

endmodule

// File: tb/irq_vector_ctl_test.sv
module irq_vector_ctl_test;

  localparam int SLOTS = 32;
  localparam int GRP   = 8;
  localparam int FW    = SLOTS * GRP;

  logic          clk = 1'b0;
  logic          rst;
  logic [FW-1:0] src_flag, src_en;
  logic          gie_wr, gie_wr_val;
  logic [3:0]    rst_src;
  logic          fetch_valid;
  logic [15:0]   fetch_addr;
  logic          ack;
  logic          irq_o;
  logic [15:0]   vec_addr_o;
  logic [4:0]    slot_o;
  logic          rst_req_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_vector_ctl uut (
    .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
    .gie_wr(gie_wr), .gie_wr_val(gie_wr_val), .rst_src(rst_src),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .ack(ack),
    .irq_o(irq_o), .vec_addr_o(vec_addr_o), .slot_o(slot_o), .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic [4:0] sa; logic [2:0] ma; logic ea;
    logic [4:0] sb; logic [2:0] mb; logic eb;
    logic       g;  logic xirq; logic [4:0] xslot;
  } row_t;

  localparam row_t ROWS [14] = '{
    '{5'd20, 3'd3, 1'b1, 5'd0,  3'd0, 1'b0, 1'b1, 1'b1, 5'd20},  // R6
    '{5'd20, 3'd3, 1'b1, 5'd0,  3'd0, 1'b0, 1'b0, 1'b0, 5'd0 },  // R6 no gie
    '{5'd20, 3'd3, 1'b0, 5'd0,  3'd0, 1'b0, 1'b1, 1'b0, 5'd0 },  // R6 no enable
    '{5'd30, 3'd1, 1'b1, 5'd0,  3'd0, 1'b0, 1'b0, 1'b1, 5'd30},  // R5
    '{5'd30, 3'd1, 1'b0, 5'd0,  3'd0, 1'b0, 1'b1, 1'b0, 5'd0 },  // R5 enable clear
    '{5'd14, 3'd7, 1'b1, 5'd29, 3'd0, 1'b1, 1'b1, 1'b1, 5'd29},  // R9
    '{5'd14, 3'd7, 1'b1, 5'd29, 3'd0, 1'b0, 1'b1, 1'b1, 5'd14},  // R7 R9
    '{5'd13, 3'd2, 1'b1, 5'd5,  3'd0, 1'b1, 1'b1, 1'b0, 5'd0 },  // R8
    '{5'd13, 3'd2, 1'b1, 5'd14, 3'd0, 1'b1, 1'b1, 1'b1, 5'd14},  // R8 R2
    '{5'd22, 3'd5, 1'b1, 5'd30, 3'd6, 1'b1, 1'b1, 1'b1, 5'd30},  // R9
    '{5'd22, 3'd5, 1'b1, 5'd30, 3'd6, 1'b1, 1'b0, 1'b1, 5'd30},  // R5
    '{5'd25, 3'd0, 1'b0, 5'd25, 3'd4, 1'b1, 1'b1, 1'b1, 5'd25},  // R7
    '{5'd31, 3'd0, 1'b1, 5'd0,  3'd0, 1'b0, 1'b1, 1'b0, 5'd0 },  // R12
    '{5'd31, 3'd0, 1'b1, 5'd16, 3'd0, 1'b1, 1'b1, 1'b1, 5'd16}   // R12
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(logic [4:0] s);
    return {10'h3FF, s, 1'b0};
  endfunction

  task automatic clear_rst_latch(string req);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    chk(req, rst_req_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; src_flag = '0; src_en = '0; gie_wr = 1'b0; gie_wr_val = 1'b0;
    rst_src = '0; fetch_valid = 1'b0; fetch_addr = 16'h8000; ack = 1'b0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 rst_req", rst_req_o, 1'b1);
    chk("R1 slot", slot_o, 5'd31);
    chk("R1 vec", vec_addr_o, 16'hFFFE);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after release", irq_o, 1'b1);
    chk("R1 slot after release", slot_o, 5'd31);
    chk("R2 reset vector", vec_addr_o, 16'hFFFE);
    clear_rst_latch("R10 ack clears reset");
    chk("R1 idle after ack", irq_o, 1'b0);

    // table walk
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      gie_wr = 1'b1; gie_wr_val = ROWS[k].g; src_flag = '0; src_en = '0;
      @(negedge clk);
      gie_wr = 1'b0;
      src_flag[int'(ROWS[k].sa)*GRP + int'(ROWS[k].ma)] = 1'b1;
      src_en  [int'(ROWS[k].sa)*GRP + int'(ROWS[k].ma)] = ROWS[k].ea;
      src_flag[int'(ROWS[k].sb)*GRP + int'(ROWS[k].mb)] = 1'b1;
      src_en  [int'(ROWS[k].sb)*GRP + int'(ROWS[k].mb)] = ROWS[k].eb;
      @(negedge clk);
      chk($sformatf("R5-9 row %0d irq", k), irq_o, ROWS[k].xirq);
      chk($sformatf("R12 row %0d no reset", k), rst_req_o, 1'b0);
      if (ROWS[k].xirq) begin
        chk($sformatf("R9 row %0d slot", k), slot_o, ROWS[k].xslot);
        chk($sformatf("R2 row %0d vec", k), vec_addr_o, exp_vec(ROWS[k].xslot));
      end
    end

    // R3: every reset cause outranks pending interrupts
    @(negedge clk);
    gie_wr = 1'b1; gie_wr_val = 1'b1; src_flag = '0; src_en = '0;
    src_flag[20*GRP] = 1'b1; src_en[20*GRP] = 1'b1;
    src_flag[30*GRP] = 1'b1; src_en[30*GRP] = 1'b1;
    @(negedge clk); gie_wr = 1'b0;
    for (int b = 0; b < 4; b++) begin
      rst_src = 4'b0001 << b;
      @(negedge clk);
      rst_src = '0;
      chk("R3 rst_req", rst_req_o, 1'b1);
      chk("R3 slot", slot_o, 5'd31);
      chk("R3 vec", vec_addr_o, 16'hFFFE);
      @(negedge clk);
      chk("R3 latched", rst_req_o, 1'b1);
      clear_rst_latch("R3 cleared by ack");
    end

    // R4: low-window fetch
    for (int a = 0; a < 5; a++) begin
      logic [15:0] addr;
      logic        v, e;
      case (a)
        0: begin addr = 16'h0000; v = 1'b1; e = 1'b1; end
        1: begin addr = 16'h01FF; v = 1'b1; e = 1'b1; end
        2: begin addr = 16'h0200; v = 1'b1; e = 1'b0; end
        3: begin addr = 16'hFFFE; v = 1'b1; e = 1'b0; end
        default: begin addr = 16'h0100; v = 1'b0; e = 1'b0; end
      endcase
      @(negedge clk);
      fetch_valid = v; fetch_addr = addr;
      @(negedge clk);
      fetch_valid = 1'b0; fetch_addr = 16'h8000;
      chk($sformatf("R4 fetch %0h", addr), rst_req_o, e);
      if (e) clear_rst_latch("R4 cleared by ack");
    end

    // R10: acknowledge clears the global enable, flags untouched
    @(negedge clk);
    gie_wr = 1'b1; gie_wr_val = 1'b1; src_flag = '0; src_en = '0;
    src_flag[20*GRP+2] = 1'b1; src_en[20*GRP+2] = 1'b1;
    @(negedge clk); gie_wr = 1'b0;
    @(negedge clk);
    chk("R10 before ack", slot_o, 5'd20);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R10 old choice one edge on", irq_o, 1'b1);
    @(negedge clk);
    chk("R10 maskable dropped", irq_o, 1'b0);
    src_flag[30*GRP+3] = 1'b1; src_en[30*GRP+3] = 1'b1;
    @(negedge clk);
    chk("R10 nmi slot", slot_o, 5'd30);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    chk("R10 nmi flag kept", irq_o, 1'b1);
    chk("R10 nmi slot kept", slot_o, 5'd30);

    // R11: ack beats a simultaneous write, then a write alone restores
    src_flag[30*GRP+3] = 1'b0;
    @(negedge clk);
    ack = 1'b1; gie_wr = 1'b1; gie_wr_val = 1'b1;
    @(negedge clk); ack = 1'b0; gie_wr = 1'b0;
    @(negedge clk);
    chk("R11 ack wins", irq_o, 1'b0);
    gie_wr = 1'b1; gie_wr_val = 1'b1;
    @(negedge clk); gie_wr = 1'b0;
    @(negedge clk);
    chk("R11 write restores irq", irq_o, 1'b1);
    chk("R11 write restores slot", slot_o, 5'd20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule